// File: doc/BRIEF.md
# USB IN Endpoint Transmit Controller

This block runs the transmit side of a single USB IN endpoint. Firmware pushes packet bytes into a local buffer, one byte per strobe, and then marks the packet as ready to go. The buffer holds one packet, or two when double buffering is switched on. When the host polls the endpoint with an IN token, the block streams the oldest ready packet out on a byte interface and tags it with the current data toggle. It answers with NAK when nothing is ready on a bulk/interrupt endpoint, and with a zero-length packet when nothing is ready on an isochronous endpoint.

For bulk/interrupt transfers, a packet stays in the buffer and the toggle holds its value until the host acknowledges the packet. A repeated token without an acknowledge gets the same packet again. For isochronous transfers, the packet is released and the toggle flipped as soon as the last byte has gone out. Firmware can make the block mark a packet ready by itself once a full maximum-size packet has been loaded. Firmware can also force a toggle flip together with a flush of the oldest packet, which is useful for rate feedback on isochronous endpoints. Serial encoding, CRC and the PHY sit outside this block.

Top module: `usb_in_ep_tx`

## Requirements
- R1: After reset, pkt_rdy and data_tog are 0, cfg_rdata reads 0x20, and tx_valid, tx_zlp and tx_nak are 0.
- R2: A cfg_wr stores cfg_wdata. cfg_rdata returns bit 7 auto-commit, bit 6 isochronous mode, and bits 5:4 as a spare field (stored and returned unchanged). Bit 3, the force action, and bits 2:1 always read 0. Bit 0 is the double-buffer enable.
- R3: On an IN token with a ready packet, the bytes go out on tx_data with tx_valid, one per cycle and in the order they were written. tx_last marks the final byte and tx_tog equals data_tog. In bulk mode the packet stays ready and data_tog is unchanged until an acknowledge arrives.
- R4: An ack_rx while a bulk packet is waiting for an acknowledge releases that packet and flips data_tog. An ack_rx at any other time has no effect.
- R5: An IN token that arrives while a bulk packet is waiting for an acknowledge resends the same bytes with the same tx_tog.
- R6: On an IN token with no ready packet, bulk mode pulses tx_nak. Isochronous mode pulses tx_zlp with tx_tog equal to data_tog and leaves data_tog unchanged.
- R7: In isochronous mode, a packet is released and data_tog flips right after its last byte, with no ack_rx needed.
- R8: fw_commit marks the bytes loaded so far as a ready packet and raises pkt_rdy. A commit with no bytes loaded makes a zero-length packet, which goes out as a tx_zlp pulse and in bulk mode waits for an acknowledge.
- R9: With auto-commit set and maxp_units nonzero, the packet is committed in the same cycle that the loaded byte count reaches maxp_units*8.
- R10: With double buffering clear, byte writes and commits are ignored while one packet is ready. With double buffering set, two packets can be ready; they go out in commit order, and pkt_rdy stays 1 until both have been released.
- R11: A cfg_wr with bit 3 set flips data_tog and discards the oldest ready packet, if there is one, even when an acknowledge arrives for it. If a packet is being streamed, the action waits until streaming ends. An IN token in the cycle the action is applied gets no response.
- R12: Byte writes beyond PKT_BYTES bytes in one packet are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration register write strobe |
| cfg_wdata | input | 8 | Configuration write value |
| cfg_rdata | output | 8 | Configuration readback |
| maxp_units | input | MAXP_W (4) | Maximum packet size in units of 8 bytes |
| fw_wr | input | 1 | Firmware byte write strobe |
| fw_data | input | 8 | Firmware byte |
| fw_commit | input | 1 | Marks the loaded bytes as a ready packet |
| pkt_rdy | output | 1 | At least one packet is ready |
| data_tog | output | 1 | Current data toggle |
| in_tok | input | 1 | IN token received strobe |
| ack_rx | input | 1 | Host acknowledge received strobe |
| tx_valid | output | 1 | tx_data carries a packet byte |
| tx_data | output | 8 | Packet byte |
| tx_last | output | 1 | Final byte of the packet |
| tx_tog | output | 1 | Toggle for the packet being sent |
| tx_zlp | output | 1 | Zero-length data packet pulse |
| tx_nak | output | 1 | NAK handshake pulse |

## Verification
Every cycle, the assertions check that the ready-packet count never goes above two, that a commit with no free slot never raises the count, that NAK never comes from an isochronous endpoint, that the toggle changes only on a release or a forced flip, and that an ack with nothing waiting leaves the toggle unchanged. Only the bench scenarios can show byte order and content, retransmission of the same packet, auto-commit at the exact size, the ordering of two buffered packets, and how the forced flush is deferred while streaming and interacts with a late acknowledge.

// File: rtl/usb_in_tx_pkg.sv
package usb_in_tx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEND = 2'd1,
        ST_WAIT = 2'd2
    } tx_state_e;

    typedef struct packed {
        logic       auto_commit;
        logic       iso_mode;
        logic [1:0] spare;
        logic       dbl_buf;
    } ep_cfg_t;

endpackage

// File: rtl/usb_in_ep_cfg.sv
module usb_in_ep_cfg
    import usb_in_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_wr,
    input  logic [7:0] cfg_wdata,
    output ep_cfg_t    cfg,
    output logic       force_req,
    output logic [7:0] cfg_rdata
);

    typedef struct packed {
        ep_cfg_t cfg;
        logic    force_pulse;
    } cfg_state_t;

    cfg_state_t st_d, st_q;

    always_comb begin
        st_d             = st_q;
        st_d.force_pulse = 1'b0;
        if (cfg_wr) begin
            st_d.cfg.auto_commit = cfg_wdata[7];
            st_d.cfg.iso_mode    = cfg_wdata[6];
            st_d.cfg.spare       = cfg_wdata[5:4];
            st_d.cfg.dbl_buf     = cfg_wdata[0];
            st_d.force_pulse     = cfg_wdata[3];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cfg.auto_commit <= 1'b0;
            st_q.cfg.iso_mode    <= 1'b0;
            st_q.cfg.spare       <= 2'b10;
            st_q.cfg.dbl_buf     <= 1'b0;
            st_q.force_pulse     <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg       = st_q.cfg;
    assign force_req = st_q.force_pulse;
    assign cfg_rdata = {st_q.cfg.auto_commit, st_q.cfg.iso_mode, st_q.cfg.spare,
                        3'b000, st_q.cfg.dbl_buf};

    // R2
    spare_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr |=> cfg_rdata == $past(cfg_rdata));

endmodule

// File: rtl/usb_in_ep_fifo.sv
module usb_in_ep_fifo #(
    parameter int PKT_BYTES = 64,
    parameter int LEN_W     = $clog2(PKT_BYTES + 1),
    parameter int IDX_W     = $clog2(PKT_BYTES),
    parameter int MAXP_W    = $clog2(PKT_BYTES / 8 + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dbl_buf,
    input  logic              auto_commit,
    input  logic [MAXP_W-1:0] maxp_units,
    input  logic              wr_en,
    input  logic [7:0]        wr_data,
    input  logic              commit_req,
    input  logic              pop,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [7:0]        rd_data,
    output logic [LEN_W-1:0]  send_len,
    output logic [1:0]        pkt_cnt
);

    localparam int ADDR_W = IDX_W + 1;
    localparam int DEPTH  = 2 * PKT_BYTES;
    localparam int CMP_W  = 16;

    typedef struct packed {
        logic                  send_slot;
        logic [1:0]            cnt;
        logic [LEN_W-1:0]      wr_len;
        logic [1:0][LEN_W-1:0] len;
    } fifo_state_t;

    fifo_state_t st_d, st_q;
    logic [7:0]  mem [DEPTH];

    logic [1:0]       cap;
    logic             space;
    logic             load_slot;
    logic             wr_ok;
    logic [LEN_W-1:0] len_after;
    logic             auto_hit;
    logic             do_commit;
    logic             do_pop;
    logic [ADDR_W-1:0] wr_addr;

    always_comb begin
        cap       = dbl_buf ? 2'd2 : 2'd1;
        space     = st_q.cnt < cap;
        load_slot = st_q.send_slot ^ (st_q.cnt == 2'd1);
        wr_ok     = wr_en && space && (int'(st_q.wr_len) < PKT_BYTES);
        len_after = st_q.wr_len + LEN_W'(wr_ok);
        auto_hit  = auto_commit && wr_ok && (maxp_units != '0) &&
                    (CMP_W'(len_after) == CMP_W'({maxp_units, 3'b000}));
        do_commit = (commit_req || auto_hit) && space;
        do_pop    = pop && (st_q.cnt != 2'd0);
        wr_addr   = {load_slot, st_q.wr_len[IDX_W-1:0]};

        st_d        = st_q;
        st_d.wr_len = len_after;
        if (do_commit) begin
            st_d.len[load_slot] = len_after;
            st_d.wr_len         = '0;
        end
        st_d.cnt = st_q.cnt + 2'(do_commit) - 2'(do_pop);
        if (do_pop) begin
            st_d.send_slot = ~st_q.send_slot;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_ok) begin
            mem[wr_addr] <= wr_data;
        end
    end

    assign rd_data  = mem[{st_q.send_slot, rd_idx}];
    assign send_len = st_q.len[st_q.send_slot];
    assign pkt_cnt  = st_q.cnt;

    // R10
    cnt_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= 2'd2);

    // R10
    no_overfill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_req && !pop && (st_q.cnt >= cap)) |=> st_q.cnt == $past(st_q.cnt));

    // R12
    len_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(st_q.wr_len) <= PKT_BYTES);

endmodule

// File: rtl/usb_in_ep_seq.sv
module usb_in_ep_seq
    import usb_in_tx_pkg::*;
#(
    parameter int LEN_W = 7,
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             iso_mode,
    input  logic             force_req,
    input  logic             in_tok,
    input  logic             ack_rx,
    input  logic [1:0]       pkt_cnt,
    input  logic [LEN_W-1:0] send_len,
    input  logic [7:0]       rd_data,
    output logic [IDX_W-1:0] rd_idx,
    output logic             pop,
    output logic             tx_valid,
    output logic [7:0]       tx_data,
    output logic             tx_last,
    output logic             tx_tog,
    output logic             tx_zlp,
    output logic             tx_nak,
    output logic             data_tog
);

    typedef struct packed {
        tx_state_e        state;
        logic [IDX_W-1:0] idx;
        logic             tog;
        logic             force_pend;
        logic             tx_valid;
        logic [7:0]       tx_data;
        logic             tx_last;
        logic             tx_tog;
        logic             tx_zlp;
        logic             tx_nak;
    } seq_state_t;

    seq_state_t st_d, st_q;
    logic       force_now;

    always_comb begin
        st_d          = st_q;
        st_d.tx_valid = 1'b0;
        st_d.tx_last  = 1'b0;
        st_d.tx_zlp   = 1'b0;
        st_d.tx_nak   = 1'b0;
        pop           = 1'b0;
        force_now     = st_q.force_pend || force_req;
        st_d.force_pend = force_now;
        rd_idx        = st_q.idx;

        if (force_now && (st_q.state != ST_SEND)) begin
            st_d.force_pend = 1'b0;
            st_d.tog        = ~st_q.tog;
            pop             = (pkt_cnt != 2'd0);
            st_d.state      = ST_IDLE;
        end else begin
            unique case (st_q.state)
                ST_IDLE, ST_WAIT: begin
                    if (in_tok) begin
                        if (pkt_cnt != 2'd0) begin
                            if (send_len == '0) begin
                                st_d.tx_zlp = 1'b1;
                                st_d.tx_tog = st_q.tog;
                                if (iso_mode) begin
                                    pop        = 1'b1;
                                    st_d.tog   = ~st_q.tog;
                                    st_d.state = ST_IDLE;
                                end else begin
                                    st_d.state = ST_WAIT;
                                end
                            end else begin
                                st_d.idx   = '0;
                                st_d.state = ST_SEND;
                            end
                        end else if (iso_mode) begin
                            st_d.tx_zlp = 1'b1;
                            st_d.tx_tog = st_q.tog;
                            st_d.state  = ST_IDLE;
                        end else begin
                            st_d.tx_nak = 1'b1;
                            st_d.state  = ST_IDLE;
                        end
                    end else if ((st_q.state == ST_WAIT) && ack_rx) begin
                        pop        = 1'b1;
                        st_d.tog   = ~st_q.tog;
                        st_d.state = ST_IDLE;
                    end
                end
                ST_SEND: begin
                    st_d.tx_valid = 1'b1;
                    st_d.tx_data  = rd_data;
                    st_d.tx_tog   = st_q.tog;
                    if ({1'b0, st_q.idx} == LEN_W'(send_len - LEN_W'(1))) begin
                        st_d.tx_last = 1'b1;
                        if (iso_mode) begin
                            pop        = 1'b1;
                            st_d.tog   = ~st_q.tog;
                            st_d.state = ST_IDLE;
                        end else begin
                            st_d.state = ST_WAIT;
                        end
                    end else begin
                        st_d.idx = st_q.idx + IDX_W'(1);
                    end
                end
                default: st_d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.state <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign tx_valid = st_q.tx_valid;
    assign tx_data  = st_q.tx_data;
    assign tx_last  = st_q.tx_last;
    assign tx_tog   = st_q.tx_tog;
    assign tx_zlp   = st_q.tx_zlp;
    assign tx_nak   = st_q.tx_nak;
    assign data_tog = st_q.tog;

    // R6
    nak_bulk_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_nak |-> $past(!iso_mode));

    // R4
    tog_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(data_tog) |-> ($past(pop) || $past(force_now)));

    // R4
    stray_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.state == ST_IDLE) && ack_rx && !in_tok && !force_now) |=> $stable(data_tog));

    // R3
    one_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({tx_valid, tx_zlp, tx_nak}) <= 1);

endmodule

// File: rtl/usb_in_ep_tx.sv
module usb_in_ep_tx
    import usb_in_tx_pkg::*;
#(
    parameter int PKT_BYTES = 64,
    parameter int MAXP_W    = $clog2(PKT_BYTES / 8 + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    input  logic [MAXP_W-1:0] maxp_units,
    input  logic              fw_wr,
    input  logic [7:0]        fw_data,
    input  logic              fw_commit,
    output logic              pkt_rdy,
    output logic              data_tog,
    input  logic              in_tok,
    input  logic              ack_rx,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              tx_last,
    output logic              tx_tog,
    output logic              tx_zlp,
    output logic              tx_nak
);

    localparam int LEN_W = $clog2(PKT_BYTES + 1);
    localparam int IDX_W = $clog2(PKT_BYTES);

    ep_cfg_t          cfg;
    logic             force_req;
    logic [IDX_W-1:0] rd_idx;
    logic [7:0]       rd_data;
    logic [LEN_W-1:0] send_len;
    logic [1:0]       pkt_cnt;
    logic             pop;

    usb_in_ep_cfg u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_wdata (cfg_wdata),
        .cfg       (cfg),
        .force_req (force_req),
        .cfg_rdata (cfg_rdata)
    );

    usb_in_ep_fifo #(
        .PKT_BYTES (PKT_BYTES),
        .LEN_W     (LEN_W),
        .IDX_W     (IDX_W),
        .MAXP_W    (MAXP_W)
    ) u_fifo (
        .clk         (clk),
        .rst_n       (rst_n),
        .dbl_buf     (cfg.dbl_buf),
        .auto_commit (cfg.auto_commit),
        .maxp_units  (maxp_units),
        .wr_en       (fw_wr),
        .wr_data     (fw_data),
        .commit_req  (fw_commit),
        .pop         (pop),
        .rd_idx      (rd_idx),
        .rd_data     (rd_data),
        .send_len    (send_len),
        .pkt_cnt     (pkt_cnt)
    );

    usb_in_ep_seq #(
        .LEN_W (LEN_W),
        .IDX_W (IDX_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .iso_mode  (cfg.iso_mode),
        .force_req (force_req),
        .in_tok    (in_tok),
        .ack_rx    (ack_rx),
        .pkt_cnt   (pkt_cnt),
        .send_len  (send_len),
        .rd_data   (rd_data),
        .rd_idx    (rd_idx),
        .pop       (pop),
        .tx_valid  (tx_valid),
        .tx_data   (tx_data),
        .tx_last   (tx_last),
        .tx_tog    (tx_tog),
        .tx_zlp    (tx_zlp),
        .tx_nak    (tx_nak),
        .data_tog  (data_tog)
    );

    assign pkt_rdy = (pkt_cnt != 2'd0);

    // R3
    valid_needs_pkt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> $past(pkt_rdy));

endmodule

// File: tb/usb_in_ep_tx_bench.sv
module usb_in_ep_tx_bench;

    localparam int PKT_BYTES = 64;
    localparam int MAXP_W    = $clog2(PKT_BYTES / 8 + 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_wr = 1'b0;
    logic [7:0]        cfg_wdata = '0;
    logic [7:0]        cfg_rdata;
    logic [MAXP_W-1:0] maxp_units = '0;
    logic              fw_wr = 1'b0;
    logic [7:0]        fw_data = '0;
    logic              fw_commit = 1'b0;
    logic              pkt_rdy, data_tog;
    logic              in_tok = 1'b0;
    logic              ack_rx = 1'b0;
    logic              tx_valid, tx_last, tx_tog, tx_zlp, tx_nak;
    logic [7:0]        tx_data;

    always #10 clk = ~clk;

    usb_in_ep_tx #(.PKT_BYTES(PKT_BYTES)) u_usb_in_ep_tx (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .maxp_units(maxp_units), .fw_wr(fw_wr),
        .fw_data(fw_data), .fw_commit(fw_commit), .pkt_rdy(pkt_rdy),
        .data_tog(data_tog), .in_tok(in_tok), .ack_rx(ack_rx),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
        .tx_tog(tx_tog), .tx_zlp(tx_zlp), .tx_nak(tx_nak)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    logic exp_tog = 1'b0;

    logic [7:0] rx_q[$];
    int last_cnt, zlp_cnt, nak_cnt;
    logic rx_tog, zlp_tog;

    always @(negedge clk) begin
        if (rst_n) begin
            if (tx_valid) begin
                rx_q.push_back(tx_data);
                rx_tog = tx_tog;
                if (tx_last) last_cnt++;
            end
            if (tx_zlp) begin
                zlp_cnt++;
                zlp_tog = tx_tog;
            end
            if (tx_nak) nak_cnt++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat_byte(input int seed, input int i);
        return 8'((seed * 37 + i * 11 + 5) & 8'hff);
    endfunction

    task automatic cfg_write(input logic [7:0] v);
        @(negedge clk); cfg_wr = 1'b1; cfg_wdata = v;
        @(negedge clk); cfg_wr = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic load_pkt(input int seed, input int n, input bit do_commit);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); fw_wr = 1'b1; fw_data = pat_byte(seed, i);
        end
        @(negedge clk); fw_wr = 1'b0;
        if (do_commit) begin
            fw_commit = 1'b1;
            @(negedge clk); fw_commit = 1'b0;
        end
        @(negedge clk);
    endtask

    task automatic token();
        rx_q.delete(); last_cnt = 0; zlp_cnt = 0; nak_cnt = 0;
        @(negedge clk); in_tok = 1'b1;
        @(negedge clk); in_tok = 1'b0;
        repeat (PKT_BYTES + 6) @(negedge clk);
    endtask

    task automatic ack();
        @(negedge clk); ack_rx = 1'b1;
        @(negedge clk); ack_rx = 1'b0;
        @(negedge clk);
    endtask

    task automatic chk_pkt(input string req, input int seed, input int n, input logic tg);
        int bad = 0;
        chk(rx_q.size() == n, req, rx_q.size(), n);
        if (n == 0) begin
            chk(zlp_cnt == 1 && zlp_tog == tg, req, {zlp_cnt, 3'b0, zlp_tog}, {1, 3'b0, tg});
        end else begin
            for (int i = 0; i < rx_q.size() && i < n; i++)
                if (rx_q[i] != pat_byte(seed, i)) bad++;
            chk(bad == 0, req, bad, 0);
            chk(last_cnt == 1 && rx_tog == tg, req, {last_cnt, 3'b0, rx_tog}, {1, 3'b0, tg});
        end
    endtask

    initial begin
        #(20 * 190000);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 1234;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(!pkt_rdy && !data_tog, "R1", {pkt_rdy, data_tog}, 0);
        chk(cfg_rdata == 8'h20, "R1", cfg_rdata, 8'h20);
        chk(!tx_valid && !tx_zlp && !tx_nak, "R1", {tx_valid, tx_zlp, tx_nak}, 0);

        // R2 readback
        cfg_write(8'hF1);
        chk(cfg_rdata == 8'hF1, "R2", cfg_rdata, 8'hF1);
        cfg_write(8'h06);
        chk(cfg_rdata == 8'h00, "R2", cfg_rdata, 8'h00);
        cfg_write(8'h20);

        // R8 R3 bulk send
        load_pkt(1, 5, 1'b1);
        chk(pkt_rdy, "R8", pkt_rdy, 1);
        token();
        chk_pkt("R3", 1, 5, exp_tog);
        chk(pkt_rdy && data_tog == exp_tog, "R3", {pkt_rdy, data_tog}, {1'b1, exp_tog});
        // R5 retransmit
        token();
        chk_pkt("R5", 1, 5, exp_tog);
        // R4 ack
        ack(); exp_tog = ~exp_tog;
        chk(!pkt_rdy && data_tog == exp_tog, "R4", {pkt_rdy, data_tog}, {1'b0, exp_tog});
        ack();
        chk(data_tog == exp_tog, "R4", data_tog, exp_tog);
        // R6 bulk NAK
        token();
        chk(nak_cnt == 1 && zlp_cnt == 0 && rx_q.size() == 0, "R6", nak_cnt, 1);

        // R10 single buffer
        load_pkt(2, 3, 1'b1);
        load_pkt(3, 4, 1'b1);
        token();
        chk_pkt("R10", 2, 3, exp_tog);
        ack(); exp_tog = ~exp_tog;
        chk(!pkt_rdy, "R10", pkt_rdy, 0);

        // R10 double buffer
        cfg_write(8'h21);
        load_pkt(4, 6, 1'b1);
        load_pkt(5, 9, 1'b1);
        token();
        chk_pkt("R10", 4, 6, exp_tog);
        ack(); exp_tog = ~exp_tog;
        chk(pkt_rdy, "R10", pkt_rdy, 1);
        token();
        chk_pkt("R10", 5, 9, exp_tog);
        ack(); exp_tog = ~exp_tog;
        chk(!pkt_rdy, "R10", pkt_rdy, 0);

        // R8 zero-length commit
        cfg_write(8'h20);
        load_pkt(6, 0, 1'b1);
        token();
        chk_pkt("R8", 6, 0, exp_tog);
        chk(pkt_rdy, "R8", pkt_rdy, 1);
        ack(); exp_tog = ~exp_tog;

        // R9 auto-commit
        cfg_write(8'hA0);
        maxp_units = 4'd1;
        load_pkt(7, 7, 1'b0);
        chk(!pkt_rdy, "R9", pkt_rdy, 0);
        @(negedge clk); fw_wr = 1'b1; fw_data = pat_byte(7, 7);
        @(negedge clk); fw_wr = 1'b0;
        chk(pkt_rdy, "R9", pkt_rdy, 1);
        token();
        chk_pkt("R9", 7, 8, exp_tog);
        ack(); exp_tog = ~exp_tog;

        // R7 isochronous
        cfg_write(8'h60);
        load_pkt(8, 4, 1'b1);
        token();
        chk_pkt("R7", 8, 4, exp_tog);
        exp_tog = ~exp_tog;
        chk(!pkt_rdy && data_tog == exp_tog, "R7", {pkt_rdy, data_tog}, {1'b0, exp_tog});
        // R6 iso empty
        token();
        chk(zlp_cnt == 1 && nak_cnt == 0 && zlp_tog == exp_tog, "R6", {zlp_cnt, nak_cnt}, {1, 0});
        chk(data_tog == exp_tog, "R6", data_tog, exp_tog);

        // R11 force flush while waiting for ack
        cfg_write(8'h20);
        load_pkt(9, 5, 1'b1);
        token();
        cfg_write(8'h28); exp_tog = ~exp_tog;
        chk(!pkt_rdy && data_tog == exp_tog, "R11", {pkt_rdy, data_tog}, {1'b0, exp_tog});
        ack();
        chk(data_tog == exp_tog, "R11", data_tog, exp_tog);
        // R11 force with empty buffer
        cfg_write(8'h28); exp_tog = ~exp_tog;
        chk(data_tog == exp_tog, "R11", data_tog, exp_tog);
        // R11 force during streaming is deferred
        load_pkt(10, 20, 1'b1);
        rx_q.delete(); last_cnt = 0; zlp_cnt = 0; nak_cnt = 0;
        @(negedge clk); in_tok = 1'b1;
        @(negedge clk); in_tok = 1'b0;
        repeat (4) @(negedge clk);
        cfg_wr = 1'b1; cfg_wdata = 8'h28;
        @(negedge clk); cfg_wr = 1'b0;
        repeat (PKT_BYTES) @(negedge clk);
        chk_pkt("R11", 10, 20, exp_tog);
        exp_tog = ~exp_tog;
        chk(!pkt_rdy && data_tog == exp_tog, "R11", {pkt_rdy, data_tog}, {1'b0, exp_tog});

        // R12 overlong load
        cfg_write(8'h20);
        load_pkt(11, PKT_BYTES + 6, 1'b1);
        token();
        chk_pkt("R12", 11, PKT_BYTES, exp_tog);
        ack(); exp_tog = ~exp_tog;

        // R3 R7 random mix
        for (int it = 0; it < 30; it++) begin
            bit iso;
            int n;
            iso = 1'($urandom % 2);
            n   = int'($urandom % (PKT_BYTES + 1));
            cfg_write({1'b0, iso, 2'b10, 4'b0000});
            load_pkt(100 + it, n, 1'b1);
            token();
            chk_pkt(iso ? "R7" : "R3", 100 + it, n, exp_tog);
            if (!iso) ack();
            exp_tog = ~exp_tog;
            chk(!pkt_rdy && data_tog == exp_tog, iso ? "R7" : "R4",
                {pkt_rdy, data_tog}, {1'b0, exp_tog});
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule